// File: doc/BRIEF.md
# Cache Event Statistics Counter Bank

This block keeps running tallies of activity in a flash cache, for debug and performance studies. The cache supplies two groups of single-cycle event pulses, one for instruction fetches and one for data reads. Each group carries four events: an access, a tag lookup, a hit found by that lookup, and a hit served from the line buffer. Every event has its own counter, so there are eight in all. Software reads the counters through a simple word-addressed read port.

A two-state machine handles the gating. In `MON_OFF`, counting is paused and every counter keeps its value. In `MON_ON`, each event pulse adds one to its counter. A write to the configuration word with the enable bit set takes the machine from `MON_OFF` to `MON_ON` (transition *start*). A write with the enable bit clear takes it back (transition *pause*). Any other write leaves the state as it is.

A second control word carries a strobe bit. Writing 1 to it zeroes all eight counters at that clock edge. The strobe is not stored, so software never has to write it back to 0.

Top module: `cache_stat_monitor`

## Requirements
- R1: After reset all eight counters read zero, the machine is in `MON_OFF`, and the configuration word at offset 0x00 reads 0.
- R2: The data-side counters read at offsets 0x40 (access), 0x44 (lookup), 0x48 (lookup hit) and 0x4C (line hit). The instruction-side counters read at 0x50, 0x54, 0x58 and 0x5C in the same event order. Offset 0x00 returns the enable state in bit 24. Every other offset reads 0.
- R3: Event inputs use bit 0 for access, bit 1 for lookup, bit 2 for lookup hit and bit 3 for line hit. Each cycle an event bit is high in `MON_ON`, only its own counter goes up by one. Counters are CNT_W bits wide (32 by default) and zero-extended onto the 32-bit read word.
- R4: Counting happens only in `MON_ON`. A write of 1 to bit 24 at offset 0x00 (*start*) takes effect from the next cycle, so an event in the same cycle as that write is not counted.
- R5: A write of 0 to bit 24 at offset 0x00 (*pause*) stops counting and holds every counter at its present value.
- R6: A write with bit 1 set at offset 0x08 zeroes all eight counters at that edge. The bit is not stored, and a write to 0x08 with bit 1 clear has no effect on the counters.
- R7: If the clear write and an event fall in the same cycle, the clear wins and the counter reads zero afterwards.
- R8: The two sides are independent, and any combination of the eight events may be high in one cycle. Each counter that sees an event is incremented.
- R9: The counters cannot be written from the bus. Writes to offsets 0x40 through 0x5C leave them unchanged.
- R10: A counter at its all-ones value wraps to zero on the next event, and no flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| d_evt | input | 4 | Data-side event pulses (bit 0 access, 1 lookup, 2 lookup hit, 3 line hit) |
| i_evt | input | 4 | Instruction-side event pulses (same bit order) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write byte offset |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read byte offset |
| rd_data | output | DATA_W | Read data for rd_addr (combinational) |

## Verification
The hardest case to reach is counter wrap. A 32-bit counter would need over four billion events to roll over. The bench therefore drives a second instance built with 6-bit counters from the same stimulus: 64 access pulses must bring it back to zero while the default instance reads 64. The clear-versus-event collision also needs care, because the clear write and all eight event bits must be driven in the same cycle. The *start* write is likewise paired with a same-cycle event, to show that the enable takes effect one cycle later.

// File: rtl/stat_mon_pkg.sv
`timescale 1ns/1ps
package stat_mon_pkg;
    localparam int EVT_PER_SIDE = 4;
    localparam int NUM_SIDES    = 2;
    localparam int NUM_CNT      = EVT_PER_SIDE * NUM_SIDES;

    // Byte offsets decoded by software.
    localparam int OFS_CFG      = 'h00;
    localparam int OFS_CTRL     = 'h08;
    localparam int OFS_CNT_BASE = 'h40;

    localparam int CFG_MON_BIT  = 24;
    localparam int CTRL_CLR_BIT = 1;

    typedef enum logic [0:0] {
        MON_OFF = 1'b0,
        MON_ON  = 1'b1
    } mon_state_t;
endpackage

// File: rtl/stat_mon_ctrl.sv
`timescale 1ns/1ps
module stat_mon_ctrl
    import stat_mon_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              run,
    output logic              clr
);
    mon_state_t st_q;
    mon_state_t st_d;
    logic       cfg_wr;
    logic       ctrl_wr;
    logic       unused_wdata;

    assign cfg_wr       = wr_en && (wr_addr == ADDR_W'(OFS_CFG));
    assign ctrl_wr      = wr_en && (wr_addr == ADDR_W'(OFS_CTRL));
    assign unused_wdata = ^wr_data;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= MON_OFF;
        else        st_q <= st_d;
    end

    // Transitions: start (OFF->ON) and pause (ON->OFF)
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            MON_OFF: if (cfg_wr && wr_data[CFG_MON_BIT])  st_d = MON_ON;
            MON_ON:  if (cfg_wr && !wr_data[CFG_MON_BIT]) st_d = MON_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        run = (st_q == MON_ON);
        clr = ctrl_wr && wr_data[CTRL_CLR_BIT];
    end
endmodule

// File: rtl/stat_counter.sv
`timescale 1ns/1ps
module stat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/stat_mon_rdmux.sv
`timescale 1ns/1ps
module stat_mon_rdmux
    import stat_mon_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int N_CNT  = 8
) (
    input  logic                     run,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic [N_CNT*CNT_W-1:0]   cnt_flat,
    output logic [DATA_W-1:0]        rd_data
);
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(OFS_CFG)) begin
            rd_data[CFG_MON_BIT] = run;
        end
        for (int k = 0; k < N_CNT; k++) begin
            if (rd_addr == ADDR_W'(OFS_CNT_BASE + 4 * k))
                rd_data = DATA_W'(cnt_flat[k*CNT_W +: CNT_W]);
        end
    end
endmodule

// File: rtl/cache_stat_monitor.sv
`timescale 1ns/1ps
module cache_stat_monitor
    import stat_mon_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        d_evt,
    input  logic [3:0]        i_evt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int N_CNT = NUM_CNT;

    logic                   mon_run;
    logic                   clr_pulse;
    logic [N_CNT-1:0]       evt_all;
    logic [N_CNT*CNT_W-1:0] cnt_flat;

    // Index 0..3 data side, 4..7 instruction side.
    assign evt_all = {i_evt, d_evt};

    stat_mon_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .run     (mon_run),
        .clr     (clr_pulse)
    );

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        stat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_pulse),
            .inc   (mon_run && evt_all[g]),
            .cnt   (cnt_flat[g*CNT_W +: CNT_W])
        );
    end

    stat_mon_rdmux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .N_CNT(N_CNT)
    ) u_rd (
        .run      (mon_run),
        .rd_addr  (rd_addr),
        .cnt_flat (cnt_flat),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/stat_mon_chk.sv
`timescale 1ns/1ps
module stat_mon_chk #(
    parameter int CNT_W = 32,
    parameter int N_CNT = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   run,
    input logic                   clr,
    input logic [N_CNT-1:0]       evt,
    input logic [N_CNT*CNT_W-1:0] cnt_flat
);
    // R6, R7: a clear strobe leaves every counter at zero
    a_r6_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_flat == '0));

    // R5: paused and no clear means all counters hold
    a_r5_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(cnt_flat));

    for (genvar k = 0; k < N_CNT; k++) begin : g_k
        // R3, R10: an enabled event adds exactly one (modulo width)
        a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
            (run && !clr && evt[k]) |=>
            (cnt_flat[k*CNT_W +: CNT_W] == $past(cnt_flat[k*CNT_W +: CNT_W]) + CNT_W'(1)));

        // R8: a counter without its own event does not move
        a_r8_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
            (!evt[k] && !clr) |=> $stable(cnt_flat[k*CNT_W +: CNT_W]));
    end
endmodule

bind cache_stat_monitor stat_mon_chk #(.CNT_W(CNT_W), .N_CNT(N_CNT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (mon_run),
    .clr      (clr_pulse),
    .evt      (evt_all),
    .cnt_flat (cnt_flat)
);

// File: tb/sim_cache_stat_monitor.sv
`timescale 1ns/1ps
module sim_cache_stat_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  d_evt = '0;
    logic [3:0]  i_evt = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] rd_data_w;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cache_stat_monitor u0 (
        .clk(clk), .rst_n(rst_n), .d_evt(d_evt), .i_evt(i_evt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    cache_stat_monitor #(.CNT_W(6)) u_wrap (
        .clk(clk), .rst_n(rst_n), .d_evt(d_evt), .i_evt(i_evt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data_w)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] cnt_ofs(input int idx);
        return 8'(8'h40 + 4 * idx);
    endfunction

    task automatic read_u0(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic check_all(input string req, input int e0, input int e1, input int e2,
                             input int e3, input int e4, input int e5, input int e6, input int e7);
        int exp [8];
        logic [31:0] v;
        exp = '{e0, e1, e2, e3, e4, e5, e6, e7};
        for (int k = 0; k < 8; k++) begin
            read_u0(cnt_ofs(k), v);
            check(req, v, 32'(exp[k]));
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fire(input logic [3:0] d, input logic [3:0] i, input int n);
        @(negedge clk);
        d_evt = d; i_evt = i;
        repeat (n) @(negedge clk);
        d_evt = '0; i_evt = '0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check_all("R1 reset", 0, 0, 0, 0, 0, 0, 0, 0);
        read_u0(8'h00, v); check("R1 cfg after reset", v, 32'h0);
    endtask

    task automatic t_disabled_ignores;
        fire(4'hF, 4'hF, 3);
        check_all("R4 off ignores events", 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_start_edge;
        logic [31:0] v;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h00; wr_data = 32'h0100_0000; d_evt = 4'b0001;
        @(negedge clk);
        wr_en = 1'b0; d_evt = '0;
        read_u0(8'h40, v); check("R4 event in start cycle not counted", v, 32'h0);
        read_u0(8'h00, v); check("R2 cfg enable bit 24", v, 32'h0100_0000);
    endtask

    task automatic t_patterns;
        fire(4'b0001, 4'b0000, 3);
        fire(4'b0010, 4'b0000, 2);
        fire(4'b0000, 4'b0100, 5);
        fire(4'b1000, 4'b1000, 1);
        check_all("R3 R2 per-event counts", 3, 2, 0, 1, 0, 0, 5, 1);
    endtask

    task automatic t_simultaneous;
        fire(4'hF, 4'hF, 4);
        check_all("R8 all events together", 7, 6, 4, 5, 4, 4, 9, 5);
        fire(4'b0101, 4'b1010, 2);
        check_all("R8 mixed sides", 9, 6, 6, 5, 4, 6, 9, 7);
    endtask

    task automatic t_pause;
        logic [31:0] v;
        reg_write(8'h00, 32'h0);
        fire(4'hF, 4'hF, 3);
        check_all("R5 pause holds", 9, 6, 6, 5, 4, 6, 9, 7);
        read_u0(8'h00, v); check("R5 cfg reads paused", v, 32'h0);
    endtask

    task automatic t_readonly;
        logic [31:0] v;
        reg_write(8'h44, 32'hFFFF_FFFF);
        reg_write(8'h58, 32'h0);
        reg_write(8'h5C, 32'h1234_5678);
        reg_write(8'h08, 32'hFFFF_FFFD);
        check_all("R9 R6 writes ignored", 9, 6, 6, 5, 4, 6, 9, 7);
        read_u0(8'h60, v); check("R2 unmapped 0x60", v, 32'h0);
        read_u0(8'h08, v); check("R6 strobe not stored", v, 32'h0);
    endtask

    task automatic t_clear;
        reg_write(8'h00, 32'h0100_0000);
        reg_write(8'h08, 32'h0000_0002);
        check_all("R6 clear all", 0, 0, 0, 0, 0, 0, 0, 0);
        fire(4'b0001, 4'b0001, 2);
        check_all("R6 counts resume without rewrite", 2, 0, 0, 0, 2, 0, 0, 0);
    endtask

    task automatic t_clear_wins;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h08; wr_data = 32'h2; d_evt = 4'hF; i_evt = 4'hF;
        @(negedge clk);
        wr_en = 1'b0; d_evt = '0; i_evt = '0;
        check_all("R7 clear beats event", 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        fire(4'b0001, 4'b0000, 63);
        read_u0(8'h40, v); check("R10 narrow at all-ones", rd_data_w, 32'd63);
        fire(4'b0001, 4'b0000, 1);
        read_u0(8'h40, v);
        check("R10 wide counter 64", v, 32'd64);
        check("R10 narrow wrapped", rd_data_w, 32'd0);
        fire(4'b0001, 4'b0000, 1);
        read_u0(8'h40, v);
        check("R10 narrow after wrap", rd_data_w, 32'd1);
        check("R3 wide keeps counting", v, 32'd65);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled_ignores();
        t_start_edge();
        t_patterns();
        t_simultaneous();
        t_pause();
        t_readonly();
        t_clear();
        t_clear_wins();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule